// File: doc/BRIEF.md
# External Bus Handover Controller

This block decides who drives a processor's external memory port: the processor core or an outside bus master. The outside master asks for the port on an asynchronous request line. The block synchronizes that line and chooses a safe point between core accesses. It first turns off every output driver of the port, then raises the grant. While the grant is up, any core access to the external port is stalled. A hold-off flag shows that the core is waiting behind the granted bus. When the outside master drops its request, the block lowers the grant. One cycle later it turns the port drivers back on, and the stalled core access goes ahead unchanged.

The core talks to the block through a request/acknowledge pair. A lock flag goes with each request. An access issued with the lock flag set ties itself to the next access, so no grant can fall between the two reads of a paired read. An unlocked read followed by a write leaves room for a grant between them. A configuration input gives the core sole use of the port. The core-side reset input only blocks the core side of the block. Arbitration keeps running while it is asserted.

Top module: `ext_bus_handover`

## Requirements
- R1: After `rst_n` is released with no request pending, `bus_grant` and `bus_hold_off` are 0 and every output-enable is 1.
- R2: When `bus_req_in` rises while the port is idle, `bus_grant` goes to 1 after the fourth rising clock edge. This is never sooner than three cycles after the request.
- R3: All output-enables (`addr_oe`, `data_oe`, every `msel_oe` bit, `boot_sel_oe`, `io_sel_oe`, `rd_oe`, `wr_oe`) go to 0 one cycle before `bus_grant` rises. They stay 0 while it is high and are still 0 in the cycle it falls.
- R4: While `bus_grant` is 1, `core_ack` stays 0. `bus_hold_off` equals `core_req` while the grant is up and is 0 otherwise. It therefore drops in the same cycle as `bus_grant`.
- R5: A core access acknowledged with `core_pair`=1 locks the port. No grant begins until a later access with `core_pair`=0 is acknowledged.
- R6: After an unlocked read is acknowledged (`core_pair`=0), a pending request is granted before the following core write is acknowledged.
- R7: While `cfg_excl` is 1, no new grant begins, and core accesses are acknowledged as usual.
- R8: When `bus_req_in` falls, `bus_grant` goes to 0 after the third rising edge. The enables return to 1 one edge later. A core request still held is then acknowledged in that same cycle.
- R9: While `core_rst` is 1, `core_ack` and `bus_hold_off` stay 0, but requests are still synchronized, granted and released.
- R10: In the idle state, if a synchronized request and a new unlocked core request meet in the same cycle, the grant wins and the core access is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the arbiter |
| core_rst | input | 1 | Core-side reset, active high, does not stop arbitration |
| cfg_excl | input | 1 | 1 = core keeps sole use of the port |
| bus_req_in | input | 1 | Asynchronous bus request from the outside master |
| core_req | input | 1 | Core wants an external access this cycle |
| core_pair | input | 1 | This access is locked to the next one |
| core_ack | output | 1 | Core access accepted this cycle |
| bus_grant | output | 1 | Port handed to the outside master |
| bus_hold_off | output | 1 | Core access waiting behind an active grant |
| addr_oe | output | 1 | Address bus driver enable |
| data_oe | output | 1 | Data bus driver enable |
| msel_oe | output | NUM_MSEL | Memory select driver enables |
| boot_sel_oe | output | 1 | Boot space select driver enable |
| io_sel_oe | output | 1 | I/O space select driver enable |
| rd_oe | output | 1 | Read strobe driver enable |
| wr_oe | output | 1 | Write strobe driver enable |

## Verification
The bench times the grant and the release edge by edge. A design that dropped a synchronizer stage, or raised the grant before turning off the drivers, would show `bus_grant` or the enables one cycle early. It holds a request up across a locked paired read and across an unlocked read/write pair. A lock that leaked would let the grant in too early, and a lock held too long would block the grant after the write. It also drives the corner cases where a request and a core access meet in the same cycle, exclusive mode is on, or the core reset is asserted. A wrong priority would acknowledge a core access in the grant cycle, and a reset that gated the arbiter would never grant the bus.

// File: rtl/ebh_pkg.sv
package ebh_pkg;
   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_CORE_BUSY  = 3'd1,
      ST_GRANT_PEND = 3'd2,
      ST_GRANTED    = 3'd3,
      ST_RELEASE    = 3'd4
   } ebh_state_e;

   // positions of the single-bit enables in the internal enable vector
   localparam int unsigned OE_ADDR  = 0;
   localparam int unsigned OE_DATA  = 1;
   localparam int unsigned OE_BOOT  = 2;
   localparam int unsigned OE_IO    = 3;
   localparam int unsigned OE_RD    = 4;
   localparam int unsigned OE_WR    = 5;
   localparam int unsigned OE_FIXED = 6;
endpackage

// File: rtl/ebh_req_sync.sv
module ebh_req_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_in};
   end

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/ebh_grant_fsm.sv
module ebh_grant_fsm
   import ebh_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic core_rst,
   input  logic cfg_excl,
   input  logic req_sync,
   input  logic core_req,
   input  logic core_pair,
   output logic core_ack,
   output logic grant_q,
   output logic drive_nxt,
   output logic locked
);
   ebh_state_e st_q, st_d;
   logic grant_go, core_ok;

   always_comb begin
      grant_go = req_sync && !cfg_excl;
      core_ok  = core_req && !core_rst;
      core_ack = 1'b0;
      st_d     = st_q;
      unique case (st_q)
         ST_IDLE: begin
            if (grant_go) st_d = ST_GRANT_PEND;
            else if (core_ok) begin
               core_ack = 1'b1;
               if (core_pair) st_d = ST_CORE_BUSY;
            end
         end
         ST_CORE_BUSY: begin
            if (core_rst) st_d = ST_IDLE;
            else if (core_ok) begin
               core_ack = 1'b1;
               if (!core_pair) st_d = ST_IDLE;
            end
         end
         ST_GRANT_PEND: st_d = ST_GRANTED;
         ST_GRANTED:    if (!req_sync) st_d = ST_RELEASE;
         ST_RELEASE:    st_d = ST_IDLE;
         default:       st_d = ST_IDLE;
      endcase
   end

   assign drive_nxt = (st_d == ST_IDLE) || (st_d == ST_CORE_BUSY);
   assign locked    = (st_q == ST_CORE_BUSY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         grant_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         grant_q <= (st_d == ST_GRANTED);
      end
   end
endmodule

// File: rtl/ebh_oe_ctrl.sv
module ebh_oe_ctrl #(
   parameter int unsigned NUM_OE        = 10,
   parameter bit          PER_BIT_FLOPS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drive_nxt,
   output logic [NUM_OE-1:0] oe
);
   if (PER_BIT_FLOPS) begin : g_per_bit
      // one flop per enable keeps the fan-out local to each pad group
      for (genvar i = 0; i < NUM_OE; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) oe[i] <= 1'b1;
            else        oe[i] <= drive_nxt;
         end
      end
   end else begin : g_shared
      logic oe_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) oe_q <= 1'b1;
         else        oe_q <= drive_nxt;
      end
      assign oe = {NUM_OE{oe_q}};
   end
endmodule

// File: rtl/ext_bus_handover.sv
module ext_bus_handover
   import ebh_pkg::*;
#(
   parameter int unsigned NUM_MSEL      = 4,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          PER_BIT_FLOPS = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                core_rst,
   input  logic                cfg_excl,
   input  logic                bus_req_in,
   input  logic                core_req,
   input  logic                core_pair,
   output logic                core_ack,
   output logic                bus_grant,
   output logic                bus_hold_off,
   output logic                addr_oe,
   output logic                data_oe,
   output logic [NUM_MSEL-1:0] msel_oe,
   output logic                boot_sel_oe,
   output logic                io_sel_oe,
   output logic                rd_oe,
   output logic                wr_oe
);
   localparam int unsigned NUM_OE = OE_FIXED + NUM_MSEL;

   if (NUM_MSEL < 1) begin : g_bad_msel
      $error("ext_bus_handover: NUM_MSEL must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ext_bus_handover: SYNC_STAGES must be at least 2");
   end

   logic              req_sync;
   logic              drive_nxt;
   logic              pair_locked;
   logic [NUM_OE-1:0] oe_vec;

   ebh_req_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (bus_req_in),
      .sync_out (req_sync)
   );

   ebh_grant_fsm fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .core_rst  (core_rst),
      .cfg_excl  (cfg_excl),
      .req_sync  (req_sync),
      .core_req  (core_req),
      .core_pair (core_pair),
      .core_ack  (core_ack),
      .grant_q   (bus_grant),
      .drive_nxt (drive_nxt),
      .locked    (pair_locked)
   );

   ebh_oe_ctrl #(.NUM_OE(NUM_OE), .PER_BIT_FLOPS(PER_BIT_FLOPS)) oe_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .drive_nxt (drive_nxt),
      .oe        (oe_vec)
   );

   assign bus_hold_off = bus_grant && core_req && !core_rst;

   assign addr_oe     = oe_vec[OE_ADDR];
   assign data_oe     = oe_vec[OE_DATA];
   assign boot_sel_oe = oe_vec[OE_BOOT];
   assign io_sel_oe   = oe_vec[OE_IO];
   assign rd_oe       = oe_vec[OE_RD];
   assign wr_oe       = oe_vec[OE_WR];
   assign msel_oe     = oe_vec[NUM_OE-1:OE_FIXED];
endmodule

// File: rtl/ebh_checker.sv
module ebh_checker (
   input logic clk,
   input logic rst_n,
   input logic core_rst,
   input logic cfg_excl,
   input logic core_req,
   input logic core_ack,
   input logic bus_grant,
   input logic bus_hold_off,
   input logic addr_oe,
   input logic rd_oe,
   input logic wr_oe,
   input logic pair_locked
);
   a_r3_quiet_while_granted: assert property (@(posedge clk) disable iff (!rst_n)
      bus_grant |-> (!addr_oe && !rd_oe && !wr_oe));

   a_r3_drivers_off_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_grant) |-> $past(!addr_oe));

   a_r3_drivers_on_after: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_grant) |-> !addr_oe);

   a_r4_stall_core: assert property (@(posedge clk) disable iff (!rst_n)
      bus_grant |-> !core_ack);

   a_r4_hold_off_cause: assert property (@(posedge clk) disable iff (!rst_n)
      bus_hold_off |-> (bus_grant && core_req));

   a_r5_lock_blocks_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_grant) |-> !$past(pair_locked, 2));

   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_grant) |-> !$past(cfg_excl, 2));

   a_r9_core_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst |-> (!core_ack && !bus_hold_off));
endmodule

bind ext_bus_handover ebh_checker chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .core_rst     (core_rst),
   .cfg_excl     (cfg_excl),
   .core_req     (core_req),
   .core_ack     (core_ack),
   .bus_grant    (bus_grant),
   .bus_hold_off (bus_hold_off),
   .addr_oe      (addr_oe),
   .rd_oe        (rd_oe),
   .wr_oe        (wr_oe),
   .pair_locked  (pair_locked)
);

// File: tb/ext_bus_handover_tb_top.sv
module ext_bus_handover_tb_top;
   localparam int unsigned NUM_MSEL = 4;
   localparam int NROWS = 23;
   // row: {br, req, pair, excl, crst, exp_bg, exp_oe, exp_ack, exp_bgh}
   localparam logic [8:0] VEC [0:NROWS-1] = '{
      9'b00000_0100, // 0  idle
      9'b01000_0110, // 1  core access acked
      9'b10000_0100, // 2  request rises
      9'b10000_0100, // 3
      9'b11000_0100, // 4  grant beats core access
      9'b11000_0000, // 5  drivers off, grant not yet
      9'b11000_1001, // 6  granted, core held off
      9'b01000_1001, // 7  request falls
      9'b01000_1001, // 8
      9'b01000_1001, // 9
      9'b01000_0000, // 10 grant dropped, drivers still off
      9'b01000_0110, // 11 drivers back, stalled access acked
      9'b00000_0100, // 12
      9'b10010_0100, // 13 exclusive mode
      9'b10010_0100, // 14
      9'b10010_0100, // 15 synced request refused
      9'b11010_0110, // 16 core still served
      9'b10000_0100, // 17 exclusive off, grant decided
      9'b00000_0000, // 18
      9'b00000_1000, // 19
      9'b00000_1000, // 20
      9'b00000_0000, // 21
      9'b00000_0100  // 22
   };

   logic clk = 1'b0;
   logic rst_n, core_rst, cfg_excl, bus_req_in, core_req, core_pair;
   logic core_ack, bus_grant, bus_hold_off;
   logic addr_oe, data_oe, boot_sel_oe, io_sel_oe, rd_oe, wr_oe;
   logic [NUM_MSEL-1:0] msel_oe;
   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   ext_bus_handover #(.NUM_MSEL(NUM_MSEL)) dut_i (
      .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .cfg_excl(cfg_excl),
      .bus_req_in(bus_req_in), .core_req(core_req), .core_pair(core_pair),
      .core_ack(core_ack), .bus_grant(bus_grant), .bus_hold_off(bus_hold_off),
      .addr_oe(addr_oe), .data_oe(data_oe), .msel_oe(msel_oe),
      .boot_sel_oe(boot_sel_oe), .io_sel_oe(io_sel_oe), .rd_oe(rd_oe), .wr_oe(wr_oe)
   );

   // {any enable on, all enables on}
   function automatic logic [1:0] oe_pair();
      logic [NUM_MSEL+5:0] v;
      v = {addr_oe, data_oe, msel_oe, boot_sel_oe, io_sel_oe, rd_oe, wr_oe};
      return {|v, &v};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input logic br, input logic req, input logic pair,
                       input logic excl, input logic crst);
      @(negedge clk);
      bus_req_in = br; core_req = req; core_pair = pair; cfg_excl = excl; core_rst = crst;
      #1;
   endtask

   task automatic release_bus(input logic req, input logic crst);
      for (int k = 0; k < 5; k++) step(1'b0, req, 1'b0, 1'b0, crst);
      check("R8 grant released", {31'd0, bus_grant}, 32'd0);
      check("R8 drivers restored", {30'd0, oe_pair()}, 32'd3);
   endtask

   function automatic string row_tag(input int i);
      if (i < 2)  return "R1";
      if (i == 4) return "R10";
      if (i < 7)  return "R2";
      if (i < 13) return "R8";
      if (i < 17) return "R7";
      return "R3";
   endfunction

   initial begin
      #(8 * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; core_rst = 1'b0; cfg_excl = 1'b0;
      bus_req_in = 1'b0; core_req = 1'b0; core_pair = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 grant after reset", {31'd0, bus_grant}, 32'd0);
      check("R1 hold-off after reset", {31'd0, bus_hold_off}, 32'd0);
      check("R1 enables after reset", {30'd0, oe_pair()}, 32'd3);

      // vector walk
      for (int i = 0; i < NROWS; i++) begin
         logic [8:0] r;
         r = VEC[i];
         step(r[8], r[7], r[6], r[5], r[4]);
         check({row_tag(i), " grant"},    {31'd0, bus_grant},    {31'd0, r[3]});
         check({row_tag(i), " enables"},  {30'd0, oe_pair()},    {30'd0, r[2], r[2]});
         check({row_tag(i), " core ack"}, {31'd0, core_ack},     {31'd0, r[1]});
         check({row_tag(i), " R4 hold-off"}, {31'd0, bus_hold_off}, {31'd0, r[0]});
      end

      // R5 locked paired read keeps the grant out
      step(1, 1, 1, 0, 0);
      check("R5 first read acked", {31'd0, core_ack}, 32'd1);
      step(1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      check("R5 no grant inside pair", {31'd0, bus_grant}, 32'd0);
      check("R5 drivers kept inside pair", {30'd0, oe_pair()}, 32'd3);
      step(1, 1, 0, 0, 0);
      check("R5 second read acked", {31'd0, core_ack}, 32'd1);
      step(1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      check("R5 drivers off after pair", {30'd0, oe_pair()}, 32'd0);
      step(1, 0, 0, 0, 0);
      check("R5 grant after pair", {31'd0, bus_grant}, 32'd1);
      release_bus(1'b0, 1'b0);

      // R6 unlocked read then write: grant slips in between
      step(1, 0, 0, 0, 0);
      step(1, 1, 0, 0, 0);
      check("R6 read acked", {31'd0, core_ack}, 32'd1);
      step(1, 1, 0, 0, 0);
      check("R6 write held for grant", {31'd0, core_ack}, 32'd0);
      step(1, 1, 0, 0, 0);
      step(1, 1, 0, 0, 0);
      check("R6 grant between read and write", {31'd0, bus_grant}, 32'd1);
      check("R6 R4 write waits with hold-off", {31'd0, bus_hold_off}, 32'd1);
      release_bus(1'b0, 1'b0);
      step(0, 1, 0, 0, 0);
      check("R8 write resumes", {31'd0, core_ack}, 32'd1);

      // R9 core reset does not stop arbitration
      for (int k = 0; k < 4; k++) begin
         step(1, 1, 0, 0, 1);
         check("R9 no ack in core reset", {31'd0, core_ack}, 32'd0);
      end
      step(1, 1, 0, 0, 1);
      check("R9 grant during core reset", {31'd0, bus_grant}, 32'd1);
      check("R9 no hold-off in core reset", {31'd0, bus_hold_off}, 32'd0);
      release_bus(1'b1, 1'b1);
      check("R9 no ack after release in core reset", {31'd0, core_ack}, 32'd0);
      step(0, 1, 0, 0, 0);
      check("R9 ack once core reset ends", {31'd0, core_ack}, 32'd1);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule